// File: doc/BRIEF.md
# Timer Update and Trigger-Output Controller

This block is the counting core of a 16-bit general-purpose timer. A clock prescaler feeds an up counter, and the counter runs from zero to an active reload limit. The prescaler divisor and the reload limit each have a preload copy that software writes and an active copy that the logic uses. The active copies change only on an update event. Update events come from a counter wrap, from a software update strobe, or from a reset pulse sent by a slave-mode controller. An update-disable control suppresses the event and the shadow loading. It still lets the strobe and the slave reset clear the counter.

A master-mode field chooses what drives the trigger output to a downstream timer: the reset pulse, the counter-enable level, or the update pulse. A separate selection picks the TI1 signal, either channel pin 1 alone or the XOR of the three channel pins. The run control is a two-state machine. `ST_HALT` moves to `ST_COUNT` (transition *start*) when the enable, which is CEN OR the gate input, is high at a clock edge. `ST_COUNT` returns to `ST_HALT` (transition *stop*) when the enable is low. Each state otherwise holds (transitions *stay-halted*, *keep-counting*). The counter and the prescaler advance only in `ST_COUNT`, so an enable change takes effect one cycle after it is registered.

Register write port (word-wide, addresses on `wr_addr_i`): address 0 is control, with bit 0 enable, bit 1 update-disable, bits 6:4 master mode and bit 7 TI1 select. Address 1 is the event strobe, with bit 0 as the update strobe. Address 2 is the prescaler preload and address 3 is the reload preload.

Top module: `tmr_update_core`

## Requirements
- R1: After reset all control fields are 0, the prescaler is 0 (preload and active), the reload is all ones (preload and active), the count is 0, and `upd_o` and `trgo_o` are low.
- R2: In `ST_COUNT` the prescaler counts from 0 to its active value PSC. The counter then steps by one, so the counter steps once every PSC+1 cycles. It wraps from the active reload value to 0 and never exceeds that value.
- R3: When update-disable (control bit 1) is 0, a counter wrap produces a one-cycle `upd_o` pulse in the cycle after the wrapping edge.
- R4: Writing 1 to bit 0 of address 1 is a self-clearing strobe. At that edge it clears the counter and the prescaler. With update-disable at 0 it also pulses `upd_o` and loads both active copies from their preloads.
- R5: With update-disable at 1, no `upd_o` pulse occurs and the active prescaler and reload keep their values. The strobe and the slave reset still clear the counter.
- R6: A high `slv_rst_i` at an edge behaves exactly like the update strobe.
- R7: The count enable is control bit 0 OR `gate_i`. While the machine is in `ST_HALT`, the count holds its value.
- R8: A high `trig_start_i` at an edge sets control bit 0. This takes priority over a write in the same cycle.
- R9: Master mode (control bits 6:4) drives `trgo_o` one cycle later. Code 000 drives the strobe/slave-reset pulse, 001 the count-enable level, 010 the update pulse, and 011 to 111 drive it low.
- R10: `ti1_o` equals `ch_i[0]` when control bit 7 is 0. It equals `ch_i[0]^ch_i[1]^ch_i[2]` when bit 7 is 1, and follows the pins in the same cycle.
- R11: Bits 15:8 and bits 3:2 of a control write have no effect.
- R12: Writes to the preload addresses do not change the counting period until an update event loads them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address |
| wr_data_i | input | 16 | Register write data |
| ch_i | input | 3 | Channel input pins |
| slv_rst_i | input | 1 | Reset pulse from slave-mode controller |
| trig_start_i | input | 1 | Trigger-mode start pulse, sets enable |
| gate_i | input | 1 | Gated-mode enable level |
| count_o | output | 16 | Counter value |
| upd_o | output | 1 | Update event pulse |
| trgo_o | output | 1 | Trigger output to slave timer |
| ti1_o | output | 1 | Selected TI1 signal |

## Verification
On every cycle, the assertions check several invariants. The count never exceeds the active reload. The count holds while halted, and a strobe or slave reset leaves it at zero. Update-disable blocks the update pulse and the active reload stays put when there is no event. A trigger start leaves the enable set, and unused master-mode codes keep the trigger output low. Only the bench scenarios can show the end-to-end behaviour. These include the exact PSC+1 cadence, a preload waiting for an update before it takes effect, the TI1 parity, and the per-mode trigger output timing. The bench compares every output each cycle against a cycle model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Register addresses
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_EVT  = 2'd1;
    localparam logic [1:0] ADDR_PSC  = 2'd2;
    localparam logic [1:0] ADDR_ARR  = 2'd3;

    // Control field positions
    localparam int BIT_CEN  = 0;
    localparam int BIT_UDIS = 1;
    localparam int MMS_LSB  = 4;
    localparam int MMS_W    = 3;
    localparam int BIT_TI1S = 7;
    localparam int BIT_UG   = 0;

    // Master-mode codes
    localparam logic [MMS_W-1:0] MM_RESET  = 3'd0;
    localparam logic [MMS_W-1:0] MM_ENABLE = 3'd1;
    localparam logic [MMS_W-1:0] MM_UPDATE = 3'd2;

    typedef enum logic {
        ST_HALT  = 1'b0,
        ST_COUNT = 1'b1
    } run_state_e;

endpackage

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              trig_start_i,
    output logic              cen_o,
    output logic              udis_o,
    output logic [MMS_W-1:0]  mms_o,
    output logic              ti1s_o,
    output logic              ug_o,
    output logic [PSC_W-1:0]  psc_pre_o,
    output logic [CNT_W-1:0]  arr_pre_o
);

    logic             cen_q, udis_q, ti1s_q;
    logic [MMS_W-1:0] mms_q;
    logic [PSC_W-1:0] psc_pre_q;
    logic [CNT_W-1:0] arr_pre_q;
    logic             wr_ctrl, wr_psc, wr_arr;

    assign wr_ctrl = wr_en_i && (wr_addr_i == ADDR_CTRL);
    assign wr_psc  = wr_en_i && (wr_addr_i == ADDR_PSC);
    assign wr_arr  = wr_en_i && (wr_addr_i == ADDR_ARR);
    assign ug_o    = wr_en_i && (wr_addr_i == ADDR_EVT) && wr_data_i[BIT_UG];

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cen_q  <= 1'b0;
            udis_q <= 1'b0;
            mms_q  <= '0;
            ti1s_q <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                cen_q  <= wr_data_i[BIT_CEN];
                udis_q <= wr_data_i[BIT_UDIS];
                mms_q  <= wr_data_i[MMS_LSB +: MMS_W];
                ti1s_q <= wr_data_i[BIT_TI1S];
            end
            if (trig_start_i) begin
                cen_q <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            psc_pre_q <= '0;
            arr_pre_q <= ARR_RST;
        end else begin
            if (wr_psc) psc_pre_q <= wr_data_i[PSC_W-1:0];
            if (wr_arr) arr_pre_q <= wr_data_i[CNT_W-1:0];
        end
    end

    assign cen_o     = cen_q;
    assign udis_o    = udis_q;
    assign mms_o     = mms_q;
    assign ti1s_o    = ti1s_q;
    assign psc_pre_o = psc_pre_q;
    assign arr_pre_o = arr_pre_q;

    // R8: a trigger start always leaves the enable set
    p_trig_cen_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        trig_start_i |=> cen_q);

endmodule

// File: rtl/tmr_count_fsm.sv
module tmr_count_fsm
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             cnt_en_i,
    input  logic             udis_i,
    input  logic             rst_evt_i,
    input  logic [PSC_W-1:0] psc_pre_i,
    input  logic [CNT_W-1:0] arr_pre_i,
    output logic [CNT_W-1:0] count_o,
    output logic             uev_o,
    output logic             upd_o
);

    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, arr_act_q;
    logic [PSC_W-1:0] psc_q, psc_d, psc_act_q;
    logic             running, tick, wrap, uev, upd_q;

    // State register
    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) state_q <= ST_HALT;
        else          state_q <= state_d;
    end

    // Transitions: start, stop, stay-halted, keep-counting
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:  if (cnt_en_i)  state_d = ST_COUNT;
            ST_COUNT: if (!cnt_en_i) state_d = ST_HALT;
            default:  state_d = ST_HALT;
        endcase
    end

    // Outputs of the state: prescaler tick, wrap, update event
    always_comb begin
        running = (state_q == ST_COUNT);
        tick    = running && !rst_evt_i && (psc_q == psc_act_q);
        wrap    = tick && (cnt_q == arr_act_q);
        uev     = !udis_i && (rst_evt_i || wrap);
        if (rst_evt_i) begin
            cnt_d = '0;
            psc_d = '0;
        end else if (running) begin
            psc_d = (psc_q == psc_act_q) ? '0 : psc_q + 1'b1;
            if (tick) cnt_d = wrap ? '0 : cnt_q + 1'b1;
            else      cnt_d = cnt_q;
        end else begin
            cnt_d = cnt_q;
            psc_d = psc_q;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            cnt_q     <= '0;
            psc_q     <= '0;
            psc_act_q <= '0;
            arr_act_q <= ARR_RST;
            upd_q     <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            psc_q <= psc_d;
            upd_q <= uev;
            if (uev) begin
                psc_act_q <= psc_pre_i;
                arr_act_q <= arr_pre_i;
            end
        end
    end

    assign count_o = cnt_q;
    assign uev_o   = uev;
    assign upd_o   = upd_q;

    // R2: the count stays within the active reload limit
    p_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        cnt_q <= arr_act_q);
    // R7: halted counter holds
    p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (state_q == ST_HALT && !rst_evt_i) |=> (cnt_q == $past(cnt_q)));
    // R4: strobe or slave reset clears the counter
    p_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        rst_evt_i |=> (cnt_q == '0 && psc_q == '0));
    // R5: update-disable suppresses the update pulse
    p_no_upd_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        udis_i |=> !upd_q);
    // R12: active reload changes only on an update event
    p_shadow_r12: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !upd_q |-> (arr_act_q == $past(arr_act_q)));

endmodule

// File: rtl/tmr_trgo_mux.sv
module tmr_trgo_mux
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 3
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic [MMS_W-1:0]  mms_i,
    input  logic              rst_evt_i,
    input  logic              cnt_en_i,
    input  logic              uev_i,
    input  logic              ti1s_i,
    input  logic [NUM_CH-1:0] ch_i,
    output logic              trgo_o,
    output logic              ti1_o
);

    logic trgo_d, trgo_q;
    logic ch_par;

    always_comb begin
        unique case (mms_i)
            MM_RESET:  trgo_d = rst_evt_i;
            MM_ENABLE: trgo_d = cnt_en_i;
            MM_UPDATE: trgo_d = uev_i;
            default:   trgo_d = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) trgo_q <= 1'b0;
        else          trgo_q <= trgo_d;
    end

    generate
        if (NUM_CH > 1) begin : g_par
            assign ch_par = ^ch_i;
        end else begin : g_single
            assign ch_par = ch_i[0];
        end
    endgenerate

    assign ti1_o  = ti1s_i ? ch_par : ch_i[0];
    assign trgo_o = trgo_q;

    // R9: unused master-mode codes keep the trigger output low
    p_trgo_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (mms_i > MM_UPDATE) |=> !trgo_q);

endmodule

// File: rtl/tmr_update_core.sv
module tmr_update_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16,
    parameter int NUM_CH = 3,
    parameter logic [CNT_W-1:0] ARR_RST = '1
) (
    input  logic              clk_i,
    input  logic              rst_n_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [NUM_CH-1:0] ch_i,
    input  logic              slv_rst_i,
    input  logic              trig_start_i,
    input  logic              gate_i,
    output logic [CNT_W-1:0]  count_o,
    output logic              upd_o,
    output logic              trgo_o,
    output logic              ti1_o
);

    logic             cen, udis, ti1s, ug, rst_evt, cnt_en, uev;
    logic [MMS_W-1:0] mms;
    logic [PSC_W-1:0] psc_pre;
    logic [CNT_W-1:0] arr_pre;

    tmr_ctrl_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W), .ARR_RST(ARR_RST)
    ) u_regs (
        .clk_i        (clk_i),
        .rst_n_i      (rst_n_i),
        .wr_en_i      (wr_en_i),
        .wr_addr_i    (wr_addr_i),
        .wr_data_i    (wr_data_i),
        .trig_start_i (trig_start_i),
        .cen_o        (cen),
        .udis_o       (udis),
        .mms_o        (mms),
        .ti1s_o       (ti1s),
        .ug_o         (ug),
        .psc_pre_o    (psc_pre),
        .arr_pre_o    (arr_pre)
    );

    assign rst_evt = ug || slv_rst_i;
    assign cnt_en  = cen || gate_i;

    tmr_count_fsm #(
        .CNT_W(CNT_W), .PSC_W(PSC_W), .ARR_RST(ARR_RST)
    ) u_count (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .cnt_en_i  (cnt_en),
        .udis_i    (udis),
        .rst_evt_i (rst_evt),
        .psc_pre_i (psc_pre),
        .arr_pre_i (arr_pre),
        .count_o   (count_o),
        .uev_o     (uev),
        .upd_o     (upd_o)
    );

    tmr_trgo_mux #(
        .NUM_CH(NUM_CH)
    ) u_trgo (
        .clk_i     (clk_i),
        .rst_n_i   (rst_n_i),
        .mms_i     (mms),
        .rst_evt_i (rst_evt),
        .cnt_en_i  (cnt_en),
        .uev_i     (uev),
        .ti1s_i    (ti1s),
        .ch_i      (ch_i),
        .trgo_o    (trgo_o),
        .ti1_o     (ti1_o)
    );

endmodule

// File: tb/tmr_update_core_tb.sv
module tmr_update_core_tb;

    localparam int MAX_CYC = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  ch = '0;
    logic        slv_rst = 1'b0, trig = 1'b0, gate = 1'b0;
    logic [15:0] count;
    logic        upd, trgo, ti1;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    tmr_update_core u_dut (
        .clk_i(clk), .rst_n_i(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .ch_i(ch), .slv_rst_i(slv_rst),
        .trig_start_i(trig), .gate_i(gate), .count_o(count), .upd_o(upd),
        .trgo_o(trgo), .ti1_o(ti1)
    );

    // Cycle model built from the requirements
    logic        m_cen, m_udis, m_ti1s, m_run, m_upd, m_trgo;
    logic [2:0]  m_mms;
    logic [15:0] m_psc_pre, m_arr_pre, m_psc_act, m_arr_act, m_psc, m_cnt;

    task automatic model_reset();
        m_cen = 0; m_udis = 0; m_ti1s = 0; m_run = 0; m_upd = 0; m_trgo = 0;
        m_mms = 0; m_psc_pre = 0; m_psc_act = 0; m_psc = 0; m_cnt = 0;
        m_arr_pre = 16'hFFFF; m_arr_act = 16'hFFFF;
    endtask

    task automatic model_step(input logic we, input logic [1:0] a,
                              input logic [15:0] d, input logic sr,
                              input logic tg, input logic gt);
        logic ug, rev, en, tick, wrap, uev;
        ug   = we && (a == 2'd1) && d[0];
        rev  = ug || sr;
        en   = m_cen || gt;
        tick = m_run && !rev && (m_psc == m_psc_act);
        wrap = tick && (m_cnt == m_arr_act);
        uev  = !m_udis && (rev || wrap);
        case (m_mms)
            3'd0:    m_trgo = rev;
            3'd1:    m_trgo = en;
            3'd2:    m_trgo = uev;
            default: m_trgo = 1'b0;
        endcase
        m_upd = uev;
        if (rev) begin
            m_cnt = 0; m_psc = 0;
        end else if (m_run) begin
            if (m_psc == m_psc_act) begin
                m_psc = 0;
                m_cnt = wrap ? 16'd0 : m_cnt + 16'd1;
            end else begin
                m_psc = m_psc + 16'd1;
            end
        end
        if (uev) begin
            m_psc_act = m_psc_pre; m_arr_act = m_arr_pre;
        end
        m_run = en;
        if (we) begin
            case (a)
                2'd0: begin
                    m_cen = d[0]; m_udis = d[1]; m_mms = d[6:4]; m_ti1s = d[7];
                end
                2'd2: m_psc_pre = d;
                2'd3: m_arr_pre = d;
                default: ;
            endcase
        end
        if (tg) m_cen = 1'b1;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic compare_model();
        check("R2 R7 count", count, m_cnt);
        check("R3 upd", {15'd0, upd}, {15'd0, m_upd});
        check("R9 trgo", {15'd0, trgo}, {15'd0, m_trgo});
        check("R10 ti1", {15'd0, ti1}, {15'd0, (m_ti1s ? ^ch : ch[0])});
    endtask

    task automatic cycle(input logic we, input logic [1:0] a, input logic [15:0] d,
                         input logic sr, input logic tg, input logic gt, input logic [2:0] c);
        @(negedge clk);
        compare_model();
        wr_en = we; wr_addr = a; wr_data = d; slv_rst = sr; trig = tg; gate = gt; ch = c;
        model_step(we, a, d, sr, tg, gt);
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        cycle(1'b1, a, d, 1'b0, 1'b0, 1'b0, ch);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, ch);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin : watchdog
        repeat (MAX_CYC) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin : main
        logic [15:0] hold;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        check("R1 count", count, 16'd0);
        check("R1 upd", {15'd0, upd}, 16'd0);
        check("R1 trgo", {15'd0, trgo}, 16'd0);

        // R12: preload does not shorten the running period
        wr(2'd2, 16'd0);
        wr(2'd3, 16'd3);
        wr(2'd0, 16'h0001);
        idle(6);
        check("R12 count past preload", count, 16'd5);

        // R4: strobe clears and updates
        wr(2'd1, 16'h0001);
        check("R4 count cleared", count, 16'd0);
        check("R4 upd pulse", {15'd0, upd}, 16'd1);
        idle(3);
        check("R2 count at limit", count, 16'd3);
        idle(1);
        check("R2 wrap to zero", count, 16'd0);
        check("R3 upd on wrap", {15'd0, upd}, 16'd1);

        // R5: update-disable
        wr(2'd0, 16'h0003);
        wr(2'd3, 16'd1);
        wr(2'd1, 16'h0001);
        check("R5 count cleared", count, 16'd0);
        check("R5 no upd", {15'd0, upd}, 16'd0);
        idle(3);
        check("R5 old reload kept", count, 16'd3);

        // R6: slave reset
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0, ch);
        check("R6 cleared udis", count, 16'd0);
        check("R6 no upd udis", {15'd0, upd}, 16'd0);
        wr(2'd0, 16'h0001);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0, ch);
        check("R6 cleared", count, 16'd0);
        check("R6 upd", {15'd0, upd}, 16'd1);
        idle(1);
        check("R6 new reload count", count, 16'd1);
        idle(1);
        check("R6 new reload wrap", count, 16'd0);
        check("R3 upd new reload", {15'd0, upd}, 16'd1);

        // R7: halted counter holds
        wr(2'd0, 16'h0000);
        idle(2);
        hold = count;
        idle(4);
        check("R7 hold", count, hold);

        // R8 and R9 enable mode
        wr(2'd0, 16'h0010);
        idle(1);
        check("R9 enable low", {15'd0, trgo}, 16'd0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b1, 1'b0, ch);
        idle(1);
        check("R8 trig sets enable", {15'd0, trgo}, 16'd1);

        // R11: reserved bits ignored
        wr(2'd0, 16'hFF1C);
        idle(1);
        check("R11 reserved ignored", {15'd0, trgo}, 16'd0);

        // R9: update and reset modes, unused code
        wr(2'd0, 16'h0020);
        wr(2'd1, 16'h0001);
        check("R9 update mode", {15'd0, trgo}, 16'd1);
        wr(2'd0, 16'h0000);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0, ch);
        check("R9 reset mode", {15'd0, trgo}, 16'd1);
        wr(2'd0, 16'h0030);
        cycle(1'b0, 2'd0, 16'd0, 1'b1, 1'b0, 1'b0, ch);
        check("R9 unused code", {15'd0, trgo}, 16'd0);

        // R10: TI1 selection
        cycle(1'b1, 2'd0, 16'h0080, 1'b0, 1'b0, 1'b0, 3'b011);
        check("R10 xor 011", {15'd0, ti1}, 16'd0);
        cycle(1'b0, 2'd0, 16'd0, 1'b0, 1'b0, 1'b0, 3'b111);
        check("R10 xor 111", {15'd0, ti1}, 16'd1);
        cycle(1'b1, 2'd0, 16'h0000, 1'b0, 1'b0, 1'b0, 3'b110);
        check("R10 direct 110", {15'd0, ti1}, 16'd0);

        // Random phase against the model
        void'($urandom(32'd20240611));
        for (int i = 0; i < 4000; i++) begin
            logic        we;
            logic [1:0]  a;
            logic [15:0] d;
            we = ($urandom % 4) == 0;
            a  = 2'($urandom % 4);
            d  = 16'($urandom);
            if (a == 2'd2) d = 16'($urandom % 3);
            if (a == 2'd3) d = 16'($urandom % 8);
            if (a == 2'd1 && ($urandom % 2) == 0) d[0] = 1'b0;
            cycle(we, a, d, ($urandom % 40) == 0, ($urandom % 40) == 0,
                  ($urandom % 5) == 0, 3'($urandom));
        end
        @(negedge clk);
        compare_model();
        finish_run();
    end

endmodule